// File: doc/BRIEF.md
# Debug Link Bring-Up Sequencer

This controller sits above two lower engines of a two-wire debug host: a raw bit-shifter that can hold the data line high for a number of clocks or shift out a short pattern, and a transaction engine that runs one complete request/acknowledge/data exchange. Out of reset, the controller runs a fixed link start-up. It drives the line high, sends the protocol-switch pattern, drives the line high again, and then reads the target's identification register. It latches the identification value and raises a link-up flag.

Once the link is up, the controller accepts register accesses from a client port, one at a time. A WAIT answer makes it issue the same access again. A FAULT answer makes it first clear the target's sticky error flags and then try again. An answer that is not a valid acknowledge means the target has stopped driving the line, so the controller drops the link and runs the whole start-up again before it tries the access once more. A programmable cap limits the number of reissues. An access that exceeds the cap completes with an error flag.

Top module: `dls_link_seq`

## Requirements
- R1: After reset, and after every restart, the block issues exactly four commands in this order: line-high shift, switch pattern shift, line-high shift, identification read. The identification read is a transaction with request byte 0xA5 and write data 0.
- R2: A line-high command has `sh_hold_high`=1, `sh_pattern`=0 and `sh_len` equal to the larger of the parameter `LR_CLKS` and 50.
- R3: The switch command has `sh_hold_high`=0, `sh_len`=16 and `sh_pattern`=0xE79E. Bit 0 of the pattern goes out first.
- R4: `link_up` rises one cycle after the identification read's `tx_done` only when `tx_ack`=3'b001 (OK) and `tx_par_ok`=1. At that point `id_code` holds that read's `tx_rdata`. Any other outcome restarts the sequence of R1.
- R5: `cl_ready` stays low, and no client request is accepted, while `link_up` is low.
- R6: A client access is sent with request byte bit0=1, bit1=`cl_ap`, bit2=`cl_rnw`, bit3=`cl_addr[0]`, bit4=`cl_addr[1]`, bit5=odd parity of bits 1 to 4 (1 when their count of ones is odd), bit6=0 and bit7=1. `tx_wdata` carries `cl_wdata`.
- R7: When an access is answered with OK (with `tx_par_ok`=1 for reads), `cl_rsp_valid` pulses one cycle after `tx_done`, with `cl_rsp_err`=0 and `cl_rsp_rdata` equal to `tx_rdata`.
- R8: A WAIT answer (3'b010), or an OK read with `tx_par_ok`=0, makes the block reissue the same request unchanged.
- R9: A FAULT answer (3'b100) makes the next transaction a debug-port write to register 0 (request byte 0x81) with data 0x1E. When that write returns OK, the original request is reissued.
- R10: Each reissue counts against `cfg_retry_max`. When a request has already been reissued `cfg_retry_max` times, its next non-OK answer completes it with `cl_rsp_err`=1 and no further transaction.
- R11: Any other acknowledge value (for example 3'b111, which is what a line that nobody drives returns) drops `link_up` one cycle after `tx_done`. The block then reruns R1 and afterwards reissues the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_retry_max | input | CNTW | Maximum number of reissues per client access |
| cl_valid | input | 1 | Client request valid |
| cl_ready | output | 1 | Client request accepted this cycle when high with valid |
| cl_ap | input | 1 | 1 selects an access-port register, 0 a debug-port register |
| cl_rnw | input | 1 | 1 for read, 0 for write |
| cl_addr | input | 2 | Register select bits |
| cl_wdata | input | 32 | Write data |
| cl_rsp_valid | output | 1 | One-cycle completion pulse |
| cl_rsp_err | output | 1 | Completion with retry cap exceeded |
| cl_rsp_rdata | output | 32 | Read data of the completed access |
| link_up | output | 1 | Link established and identification latched |
| id_code | output | 32 | Latched identification value |
| sh_start | output | 1 | One-cycle command to the raw shifter |
| sh_hold_high | output | 1 | Shifter holds the line high instead of shifting the pattern |
| sh_len | output | LENW | Number of clocks for the shifter command |
| sh_pattern | output | 16 | Pattern for the shifter, bit 0 first |
| sh_done | input | 1 | Shifter command finished |
| tx_start | output | 1 | One-cycle command to the transaction engine |
| tx_req | output | 8 | Request byte, bit 0 first on the line |
| tx_wdata | output | 32 | Write data for the transaction |
| tx_done | input | 1 | Transaction finished, answer fields valid |
| tx_ack | input | 3 | Received acknowledge |
| tx_rdata | input | 32 | Received read data |
| tx_par_ok | input | 1 | Read data parity matched |

## Verification
The bench stands in for both lower engines and answers each command from a scripted reply list. Each command and each completion the block produces is compared in order against a queue of expected items. That queue fixes the sequence of R1, the retry and recovery orderings of R8 to R11, and the absence of early accesses (R5). Timing is checked in cycles relative to the bench's own `tx_done` pulse. Completions (R7), the rise of `link_up` (R4) and its fall (R11) are each due in exactly the cycle after `tx_done`, and the bench compares the cycle in which it observes them against that count.

// File: rtl/dls_pkg.sv
package dls_pkg;

  localparam logic [2:0]  ACK_OK     = 3'b001;
  localparam logic [2:0]  ACK_WAIT   = 3'b010;
  localparam logic [2:0]  ACK_FAULT  = 3'b100;
  localparam logic [15:0] SWITCH_PAT = 16'hE79E;
  localparam int          SWITCH_LEN = 16;
  localparam int          LR_MIN     = 50;
  localparam logic [31:0] STICKY_CLR = 32'h0000_001E;

  typedef enum logic [1:0] {
    ACKC_OK,
    ACKC_RETRY,
    ACKC_FAULT,
    ACKC_LOST
  } ack_class_e;

  // Request byte, bit 0 goes out first on the wire.
  function automatic logic [7:0] req_byte(input logic ap, input logic rnw,
                                          input logic [1:0] addr);
    req_byte = {1'b1, 1'b0, ^{ap, rnw, addr}, addr[1], addr[0], rnw, ap, 1'b1};
  endfunction

  function automatic ack_class_e classify(input logic [2:0] ack);
    case (ack)
      ACK_OK:    classify = ACKC_OK;
      ACK_WAIT:  classify = ACKC_RETRY;
      ACK_FAULT: classify = ACKC_FAULT;
      default:   classify = ACKC_LOST;
    endcase
  endfunction

  localparam logic [7:0] ID_REQ  = 8'hA5;
  localparam logic [7:0] CLR_REQ = 8'h81;

endpackage

// File: rtl/dls_rst_sync.sv
module dls_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dls_bringup.sv
module dls_bringup
  import dls_pkg::*;
#(
  parameter int LR_LEN = 50,
  parameter int LENW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            relink,
  output logic            sh_start,
  output logic            sh_hold_high,
  output logic [LENW-1:0] sh_len,
  output logic [15:0]     sh_pattern,
  input  logic            sh_done,
  output logic            tx_start,
  output logic [7:0]      tx_req,
  input  logic            tx_done,
  input  logic [2:0]      tx_ack,
  input  logic [31:0]     tx_rdata,
  input  logic            tx_par_ok,
  output logic            link_up,
  output logic [31:0]     id_code
);

  typedef enum logic [3:0] {
    BU_START, BU_LR1, BU_LR1_W, BU_SW, BU_SW_W,
    BU_LR2, BU_LR2_W, BU_ID, BU_ID_W, BU_UP
  } bu_state_e;

  bu_state_e   state_q, state_d;
  logic        id_en;
  logic [31:0] id_q;

  always_comb begin
    state_d      = state_q;
    sh_start     = 1'b0;
    sh_hold_high = 1'b0;
    sh_len       = '0;
    sh_pattern   = '0;
    tx_start     = 1'b0;
    id_en        = 1'b0;
    case (state_q)
      BU_START: state_d = BU_LR1;
      BU_LR1: begin
        sh_start     = 1'b1;
        sh_hold_high = 1'b1;
        sh_len       = LENW'(LR_LEN);
        state_d      = BU_LR1_W;
      end
      BU_LR1_W: if (sh_done) state_d = BU_SW;
      BU_SW: begin
        sh_start   = 1'b1;
        sh_len     = LENW'(SWITCH_LEN);
        sh_pattern = SWITCH_PAT;
        state_d    = BU_SW_W;
      end
      BU_SW_W: if (sh_done) state_d = BU_LR2;
      BU_LR2: begin
        sh_start     = 1'b1;
        sh_hold_high = 1'b1;
        sh_len       = LENW'(LR_LEN);
        state_d      = BU_LR2_W;
      end
      BU_LR2_W: if (sh_done) state_d = BU_ID;
      BU_ID: begin
        tx_start = 1'b1;
        state_d  = BU_ID_W;
      end
      BU_ID_W: begin
        if (tx_done) begin
          if (tx_ack == ACK_OK && tx_par_ok) begin
            id_en   = 1'b1;
            state_d = BU_UP;
          end else begin
            state_d = BU_LR1;
          end
        end
      end
      BU_UP: if (relink) state_d = BU_LR1;
      default: state_d = BU_LR1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= BU_START;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     id_q <= '0;
    else if (id_en) id_q <= tx_rdata;
  end

  assign tx_req  = ID_REQ;
  assign link_up = (state_q == BU_UP);
  assign id_code = id_q;

  AST_LINK_NEEDS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(tx_done && tx_ack == ACK_OK && tx_par_ok)); // R4
  AST_ID_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> id_code == $past(tx_rdata)); // R4
  AST_LR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start && sh_hold_high |-> int'(sh_len) >= LR_MIN); // R2

endmodule

// File: rtl/dls_access.sv
module dls_access
  import dls_pkg::*;
#(
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            link_up,
  input  logic [CNTW-1:0] cfg_retry_max,
  input  logic            cl_valid,
  output logic            cl_ready,
  input  logic            cl_ap,
  input  logic            cl_rnw,
  input  logic [1:0]      cl_addr,
  input  logic [31:0]     cl_wdata,
  output logic            cl_rsp_valid,
  output logic            cl_rsp_err,
  output logic [31:0]     cl_rsp_rdata,
  output logic            tx_start,
  output logic [7:0]      tx_req,
  output logic [31:0]     tx_wdata,
  input  logic            tx_done,
  input  logic [2:0]      tx_ack,
  input  logic [31:0]     tx_rdata,
  input  logic            tx_par_ok,
  output logic            relink
);

  typedef enum logic [2:0] {
    AC_IDLE, AC_ISSUE, AC_WAIT, AC_CLR, AC_CLR_W, AC_RELINK, AC_RSP
  } ac_state_e;

  ac_state_e       state_q, state_d;
  logic            ap_q, rnw_q;
  logic [1:0]      addr_q;
  logic [31:0]     wdata_q;
  logic            req_ld;
  logic [CNTW-1:0] cnt_q;
  logic            cnt_clr, cnt_inc, at_limit;
  logic            rsp_ld, rsp_err_d, rsp_err_q;
  logic [31:0]     rsp_data_q;
  ack_class_e      cls_raw, cls_acc;

  always_comb begin
    cls_raw = classify(tx_ack);
    cls_acc = cls_raw;
    if (cls_raw == ACKC_OK && rnw_q && !tx_par_ok) cls_acc = ACKC_RETRY;
  end

  assign at_limit = (cnt_q >= cfg_retry_max);

  always_comb begin
    state_d   = state_q;
    req_ld    = 1'b0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    rsp_ld    = 1'b0;
    rsp_err_d = 1'b0;
    relink    = 1'b0;
    cl_ready  = 1'b0;
    tx_start  = 1'b0;
    tx_req    = req_byte(ap_q, rnw_q, addr_q);
    tx_wdata  = wdata_q;
    case (state_q)
      AC_IDLE: begin
        cl_ready = link_up;
        if (cl_valid && link_up) begin
          req_ld  = 1'b1;
          cnt_clr = 1'b1;
          state_d = AC_ISSUE;
        end
      end
      AC_ISSUE: begin
        tx_start = 1'b1;
        state_d  = AC_WAIT;
      end
      AC_WAIT: begin
        if (tx_done) begin
          case (cls_acc)
            ACKC_OK: begin
              rsp_ld  = 1'b1;
              state_d = AC_RSP;
            end
            ACKC_RETRY, ACKC_FAULT: begin
              if (at_limit) begin
                rsp_ld    = 1'b1;
                rsp_err_d = 1'b1;
                state_d   = AC_RSP;
              end else begin
                cnt_inc = 1'b1;
                state_d = (cls_acc == ACKC_FAULT) ? AC_CLR : AC_ISSUE;
              end
            end
            default: begin
              relink = 1'b1;
              if (at_limit) begin
                rsp_ld    = 1'b1;
                rsp_err_d = 1'b1;
                state_d   = AC_RSP;
              end else begin
                cnt_inc = 1'b1;
                state_d = AC_RELINK;
              end
            end
          endcase
        end
      end
      AC_CLR: begin
        tx_start = 1'b1;
        tx_req   = CLR_REQ;
        tx_wdata = STICKY_CLR;
        state_d  = AC_CLR_W;
      end
      AC_CLR_W: begin
        if (tx_done) begin
          if (cls_raw == ACKC_OK) begin
            state_d = AC_ISSUE;
          end else begin
            if (cls_raw == ACKC_LOST) relink = 1'b1;
            if (at_limit) begin
              rsp_ld    = 1'b1;
              rsp_err_d = 1'b1;
              state_d   = AC_RSP;
            end else begin
              cnt_inc = 1'b1;
              state_d = (cls_raw == ACKC_LOST) ? AC_RELINK : AC_CLR;
            end
          end
        end
      end
      AC_RELINK: if (link_up) state_d = AC_ISSUE;
      AC_RSP:    state_d = AC_IDLE;
      default:   state_d = AC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= AC_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_q    <= 1'b0;
      rnw_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_ld) begin
      ap_q    <= cl_ap;
      rnw_q   <= cl_rnw;
      addr_q  <= cl_addr;
      wdata_q <= cl_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_clr) cnt_q <= '0;
    else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_err_q  <= 1'b0;
      rsp_data_q <= '0;
    end else if (rsp_ld) begin
      rsp_err_q  <= rsp_err_d;
      rsp_data_q <= tx_rdata;
    end
  end

  assign cl_rsp_valid = (state_q == AC_RSP);
  assign cl_rsp_err   = rsp_err_q;
  assign cl_rsp_rdata = rsp_data_q;

  AST_RSP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cl_rsp_valid |-> $past(tx_done)); // R7
  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == AC_WAIT && tx_done && tx_ack == ACK_FAULT && !at_limit
      |=> tx_start && tx_req == CLR_REQ && tx_wdata == STICKY_CLR); // R9
  AST_RELINK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    relink |=> !link_up); // R11

endmodule

// File: rtl/dls_link_seq.sv
module dls_link_seq
  import dls_pkg::*;
#(
  parameter  int LR_CLKS = 64,
  parameter  int CNTW    = 4,
  localparam int LR_LEN  = (LR_CLKS < LR_MIN) ? LR_MIN : LR_CLKS,
  localparam int LENW    = $clog2(LR_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CNTW-1:0] cfg_retry_max,
  input  logic            cl_valid,
  output logic            cl_ready,
  input  logic            cl_ap,
  input  logic            cl_rnw,
  input  logic [1:0]      cl_addr,
  input  logic [31:0]     cl_wdata,
  output logic            cl_rsp_valid,
  output logic            cl_rsp_err,
  output logic [31:0]     cl_rsp_rdata,
  output logic            link_up,
  output logic [31:0]     id_code,
  output logic            sh_start,
  output logic            sh_hold_high,
  output logic [LENW-1:0] sh_len,
  output logic [15:0]     sh_pattern,
  input  logic            sh_done,
  output logic            tx_start,
  output logic [7:0]      tx_req,
  output logic [31:0]     tx_wdata,
  input  logic            tx_done,
  input  logic [2:0]      tx_ack,
  input  logic [31:0]     tx_rdata,
  input  logic            tx_par_ok
);

  logic        rst_sync_n;
  logic        relink;
  logic        bu_tx_start, ac_tx_start;
  logic [7:0]  bu_tx_req, ac_tx_req;
  logic [31:0] ac_tx_wdata;

  dls_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dls_bringup #(.LR_LEN(LR_LEN), .LENW(LENW)) u_bringup (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .relink       (relink),
    .sh_start     (sh_start),
    .sh_hold_high (sh_hold_high),
    .sh_len       (sh_len),
    .sh_pattern   (sh_pattern),
    .sh_done      (sh_done),
    .tx_start     (bu_tx_start),
    .tx_req       (bu_tx_req),
    .tx_done      (tx_done),
    .tx_ack       (tx_ack),
    .tx_rdata     (tx_rdata),
    .tx_par_ok    (tx_par_ok),
    .link_up      (link_up),
    .id_code      (id_code)
  );

  dls_access #(.CNTW(CNTW)) u_access (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .link_up       (link_up),
    .cfg_retry_max (cfg_retry_max),
    .cl_valid      (cl_valid),
    .cl_ready      (cl_ready),
    .cl_ap         (cl_ap),
    .cl_rnw        (cl_rnw),
    .cl_addr       (cl_addr),
    .cl_wdata      (cl_wdata),
    .cl_rsp_valid  (cl_rsp_valid),
    .cl_rsp_err    (cl_rsp_err),
    .cl_rsp_rdata  (cl_rsp_rdata),
    .tx_start      (ac_tx_start),
    .tx_req        (ac_tx_req),
    .tx_wdata      (ac_tx_wdata),
    .tx_done       (tx_done),
    .tx_ack        (tx_ack),
    .tx_rdata      (tx_rdata),
    .tx_par_ok     (tx_par_ok),
    .relink        (relink)
  );

  // Bring-up owns the engine while the link is down, the access side after.
  assign tx_start = bu_tx_start | ac_tx_start;
  assign tx_req   = link_up ? ac_tx_req   : bu_tx_req;
  assign tx_wdata = link_up ? ac_tx_wdata : '0;

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bu_tx_start && ac_tx_start)); // R5

endmodule

// File: tb/dls_link_seq_tb.sv
module dls_link_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LR_SET     = 20;
  localparam int LR_EXP     = 50;
  localparam int LW         = 6;
  localparam logic [31:0] ID_VAL = 32'h2BA0_1477;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_retry_max = 4'd4;
  logic        cl_valid = 1'b0, cl_ap = 1'b0, cl_rnw = 1'b0;
  logic [1:0]  cl_addr = 2'd0;
  logic [31:0] cl_wdata = '0;
  logic        cl_ready, cl_rsp_valid, cl_rsp_err;
  logic [31:0] cl_rsp_rdata, id_code;
  logic        link_up;
  logic        sh_start, sh_hold_high;
  logic [LW-1:0] sh_len;
  logic [15:0] sh_pattern;
  logic        sh_done = 1'b0;
  logic        tx_start;
  logic [7:0]  tx_req;
  logic [31:0] tx_wdata;
  logic        tx_done = 1'b0;
  logic [2:0]  tx_ack = 3'b000;
  logic [31:0] tx_rdata = '0;
  logic        tx_par_ok = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dls_link_seq #(.LR_CLKS(LR_SET), .CNTW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_retry_max(cfg_retry_max),
    .cl_valid(cl_valid), .cl_ready(cl_ready), .cl_ap(cl_ap), .cl_rnw(cl_rnw),
    .cl_addr(cl_addr), .cl_wdata(cl_wdata), .cl_rsp_valid(cl_rsp_valid),
    .cl_rsp_err(cl_rsp_err), .cl_rsp_rdata(cl_rsp_rdata), .link_up(link_up),
    .id_code(id_code), .sh_start(sh_start), .sh_hold_high(sh_hold_high),
    .sh_len(sh_len), .sh_pattern(sh_pattern), .sh_done(sh_done),
    .tx_start(tx_start), .tx_req(tx_req), .tx_wdata(tx_wdata),
    .tx_done(tx_done), .tx_ack(tx_ack), .tx_rdata(tx_rdata), .tx_par_ok(tx_par_ok)
  );

  typedef struct packed {
    logic [1:0]  kind;   // 0 shifter, 1 transaction, 2 completion
    logic [31:0] a;
    logic [31:0] b;
  } item_t;
  typedef struct packed {
    logic [2:0]  ack;
    logic        par;
    logic [31:0] data;
  } reply_t;

  item_t  exp_q[$];
  reply_t rep_q[$];
  int n_chk = 0, n_bad = 0;
  int cyc = 0, last_done_cyc = -10;
  int sh_wait = 0, tx_wait = 0;
  reply_t cur;
  logic prev_link = 1'b0;
  bit finished = 0;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_req(input bit ap, input bit rnw, input bit [1:0] a);
    logic [7:0] r;
    int ones;
    ones = int'(ap) + int'(rnw) + int'(a[0]) + int'(a[1]);
    r = 8'h81;
    r[1] = ap; r[2] = rnw; r[3] = a[0]; r[4] = a[1];
    r[5] = (ones % 2) == 1;
    return r;
  endfunction

  task automatic observe(input logic [1:0] kind, input logic [31:0] a,
                         input logic [31:0] b, input string req);
    item_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, {req, " unexpected item"}, {30'b0, kind, a}, '0);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind && e.a == a, req, {30'b0, kind, a}, {30'b0, e.kind, e.a});
      check(e.b == b, req, {32'b0, b}, {32'b0, e.b});
    end
  endtask

  // Monitor and models of the two lower engines.
  always @(negedge clk) begin
    cyc++;
    sh_done = 1'b0;
    tx_done = 1'b0;
    if (rst_n) begin
      if (sh_wait > 0) begin
        sh_wait--;
        if (sh_wait == 0) sh_done = 1'b1;
      end
      if (tx_wait > 0) begin
        tx_wait--;
        if (tx_wait == 0) begin
          tx_done = 1'b1; tx_ack = cur.ack; tx_par_ok = cur.par; tx_rdata = cur.data;
          last_done_cyc = cyc;
        end
      end
      if (sh_start) begin
        observe(2'd0, {25'b0, sh_hold_high, sh_len}, {16'b0, sh_pattern}, "R1/R2/R3 shifter cmd");
        sh_wait = 3;
      end
      if (tx_start) begin
        observe(2'd1, {24'b0, tx_req}, tx_wdata, "R1/R6/R8/R9 transaction");
        if (rep_q.size() == 0) begin
          check(1'b0, "R1 no scripted reply", '0, '0);
          cur = '{ack: 3'b111, par: 1'b0, data: '0};
        end else cur = rep_q.pop_front();
        tx_wait = 2;
      end
      if (cl_rsp_valid) begin
        observe(2'd2, {31'b0, cl_rsp_err}, cl_rsp_err ? 32'b0 : cl_rsp_rdata, "R7/R10 completion");
        check(cyc == last_done_cyc + 1, "R7 completion latency", 64'(cyc), 64'(last_done_cyc + 1));
      end
      if (link_up && !prev_link)
        check(cyc == last_done_cyc + 1, "R4 link_up rise latency", 64'(cyc), 64'(last_done_cyc + 1));
      if (!link_up && prev_link)
        check(cyc == last_done_cyc + 1, "R11 link_up fall latency", 64'(cyc), 64'(last_done_cyc + 1));
      prev_link = link_up;
    end
  end

  task automatic exp_bringup();
    exp_q.push_back('{kind: 2'd0, a: {25'b0, 1'b1, 6'(LR_EXP)}, b: 32'h0});
    exp_q.push_back('{kind: 2'd0, a: {25'b0, 1'b0, 6'd16}, b: 32'h0000_E79E});
    exp_q.push_back('{kind: 2'd0, a: {25'b0, 1'b1, 6'(LR_EXP)}, b: 32'h0});
    exp_q.push_back('{kind: 2'd1, a: 32'h0000_00A5, b: 32'h0});
  endtask

  task automatic exp_tx(input bit ap, input bit rnw, input bit [1:0] a, input logic [31:0] wd);
    exp_q.push_back('{kind: 2'd1, a: {24'b0, tb_req(ap, rnw, a)}, b: wd});
  endtask

  task automatic exp_rsp(input bit err, input logic [31:0] d);
    exp_q.push_back('{kind: 2'd2, a: {31'b0, err}, b: err ? 32'b0 : d});
  endtask

  task automatic reply(input logic [2:0] ack, input bit par, input logic [31:0] d);
    rep_q.push_back('{ack: ack, par: par, data: d});
  endtask

  task automatic do_req(input bit ap, input bit rnw, input bit [1:0] a, input logic [31:0] wd);
    cl_ap = ap; cl_rnw = rnw; cl_addr = a; cl_wdata = wd; cl_valid = 1'b1;
    while (!cl_ready) @(negedge clk);
    @(negedge clk);
    cl_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(rep_q.size() == 0, "R1 all replies consumed", 64'(rep_q.size()), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(link_up == 1'b0, "R4 reset link_up", 64'(link_up), 0);
    check(cl_ready == 1'b0, "R5 reset cl_ready", 64'(cl_ready), 0);
    check(cl_rsp_valid == 1'b0 && sh_start == 1'b0 && tx_start == 1'b0,
          "R1 reset quiet", 64'({cl_rsp_valid, sh_start, tx_start}), 0);

    // R4: first identification read has bad parity, sequence restarts.
    exp_bringup(); reply(3'b001, 1'b0, 32'h1234_5678);
    exp_bringup(); reply(3'b001, 1'b1, ID_VAL);
    // R5: request presented during bring-up must follow it.
    exp_tx(1'b0, 1'b1, 2'd1, 32'h0); reply(3'b001, 1'b1, 32'hCAFE_0001);
    exp_rsp(1'b0, 32'hCAFE_0001);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(cl_ready == 1'b0, "R5 held off during bring-up", 64'(cl_ready), 0);
    do_req(1'b0, 1'b1, 2'd1, 32'h0);
    drain();
    check(link_up == 1'b1, "R4 link up", 64'(link_up), 1);
    check(id_code == ID_VAL, "R4 id latched", 64'(id_code), 64'(ID_VAL));

    // R6/R7: access-port write.
    exp_tx(1'b1, 1'b0, 2'd3, 32'hA5A5_0F0F); reply(3'b001, 1'b0, 32'h0);
    exp_rsp(1'b0, 32'h0);
    do_req(1'b1, 1'b0, 2'd3, 32'hA5A5_0F0F); drain();

    // R8: two WAIT answers then OK.
    for (int i = 0; i < 3; i++) exp_tx(1'b1, 1'b1, 2'd2, 32'h0);
    reply(3'b010, 1'b0, 32'h0); reply(3'b010, 1'b0, 32'h0); reply(3'b001, 1'b1, 32'h0000_BEEF);
    exp_rsp(1'b0, 32'h0000_BEEF);
    do_req(1'b1, 1'b1, 2'd2, 32'h0); drain();

    // R8: read with bad data parity then good.
    exp_tx(1'b1, 1'b1, 2'd0, 32'h0); exp_tx(1'b1, 1'b1, 2'd0, 32'h0);
    reply(3'b001, 1'b0, 32'h1111_1111); reply(3'b001, 1'b1, 32'h2222_2222);
    exp_rsp(1'b0, 32'h2222_2222);
    do_req(1'b1, 1'b1, 2'd0, 32'h0); drain();

    // R9: FAULT, sticky clear, reissue.
    exp_tx(1'b1, 1'b0, 2'd1, 32'h0000_0042);
    exp_q.push_back('{kind: 2'd1, a: 32'h0000_0081, b: 32'h0000_001E});
    exp_tx(1'b1, 1'b0, 2'd1, 32'h0000_0042);
    reply(3'b100, 1'b0, 32'h0); reply(3'b001, 1'b0, 32'h0); reply(3'b001, 1'b0, 32'h0);
    exp_rsp(1'b0, 32'h0);
    do_req(1'b1, 1'b0, 2'd1, 32'h0000_0042); drain();

    // R10: cap of 2 reissues, third WAIT times out.
    cfg_retry_max = 4'd2;
    for (int i = 0; i < 3; i++) begin
      exp_tx(1'b0, 1'b1, 2'd3, 32'h0); reply(3'b010, 1'b0, 32'h0);
    end
    exp_rsp(1'b1, 32'h0);
    do_req(1'b0, 1'b1, 2'd3, 32'h0); drain();
    check(link_up == 1'b1, "R10 link kept after timeout", 64'(link_up), 1);
    cfg_retry_max = 4'd4;

    // R11: no response, full bring-up, then reissue.
    exp_tx(1'b1, 1'b1, 2'd1, 32'h0); reply(3'b111, 1'b0, 32'h0);
    exp_bringup(); reply(3'b001, 1'b1, ID_VAL ^ 32'h1);
    exp_tx(1'b1, 1'b1, 2'd1, 32'h0); reply(3'b001, 1'b1, 32'h7777_0000);
    exp_rsp(1'b0, 32'h7777_0000);
    do_req(1'b1, 1'b1, 2'd1, 32'h0); drain();
    check(id_code == (ID_VAL ^ 32'h1), "R11 id relatched", 64'(id_code), 64'(ID_VAL ^ 32'h1));

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!finished) begin
      check(1'b0, "R1 watchdog expired", 64'(exp_q.size()), 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule